// File: doc/BRIEF.md
# Display Timing Generator with Shadowed Configuration

This block generates the raster timing for a parallel RGB panel: horizontal and vertical sync pulses, a data-enable strobe, the active pixel column and row, a last-active-line marker and a pixel-clock enable. Both axes walk the same four segments in a fixed order: sync, back porch, active, front porch. A horizontal line ends after its front porch, and the vertical axis then advances by one line. The frame wraps when the last front-porch line ends.

Software programs the block through a one-cycle write port. Timing fields land in a shadow set and never disturb the frame in progress. The shadow set is copied into the running set only at a frame boundary, and only when an update has been requested. The request clears itself once the copy is made. A frame interrupt pending flag is raised at the start of vertical sync and is cleared by writing one. A software reset pulse returns both axes to the start of vertical sync and counts as a frame boundary. The pixel-clock enable divides the system clock by an integer ratio.

Each axis is a four-state machine with states SEG_SYNC, SEG_BACK, SEG_ACTIVE and SEG_FRONT. On a step in which the segment counter equals the programmed length minus one, the transitions are SEG_SYNC to SEG_BACK, SEG_BACK to SEG_ACTIVE, SEG_ACTIVE to SEG_FRONT, and SEG_FRONT to SEG_SYNC (the wrap). A software reset forces any state to SEG_SYNC with a zero count. The horizontal axis steps on every pixel enable. The vertical axis steps when the horizontal axis wraps.

Top module: `disp_timing_gen`

## Requirements
- R1: The horizontal order is sync, back porch, active, front porch. Address 2 holds sync width minus one in bits [7:0], back porch minus one in [15:8] and front porch minus one in [23:16]. hsync is high exactly during the sync pixels.
- R2: The vertical order is the same, counted in lines. Address 1 uses the same field layout as address 2. vsync is high during the sync lines.
- R3: Address 3 holds active width minus one in [11:0] and active height minus one in [27:16]. pix_x and pix_y count from 0 inside the active segment of their axis and read 0 outside it.
- R4: Timing writes (addresses 1 to 4) have no effect on the running frame. They are copied into the running set at the next frame boundary after an update request (address 0 bit 4). One request produces exactly one copy and then clears itself.
- R5: If the interrupt enable (address 0 bit 2) is set, frame_irq goes high at the start of vertical sync. Writing 1 to address 6 bit 0 clears it. Writing 0 leaves it unchanged.
- R6: Address 5 [7:0] holds the divide ratio minus one. pix_ce is high on one cycle in every ratio cycles. Ratio 1 gives pix_ce on every cycle. A field value of 255 is clamped to a ratio of 255. A new ratio applies immediately.
- R7: de is high only inside both active segments, while the direct video enable (address 0 bit 0) is set and the frame-synchronised video enable is set. The frame-synchronised enable takes the value of address 0 bit 1 at each frame boundary.
- R8: Address 4 [11:0] holds a line threshold, which is part of the shadowed set. last_line is high throughout the active line whose row index equals the threshold.
- R9: Writing address 0 with bit 3 set returns both axes and the divider to the start of vertical sync and clears frame_irq. This write counts as a frame boundary for R4 and R7.
- R10: After reset, both axes are at the start of sync, de and frame_irq are low, every sync and porch length is 1, active size is 4 by 4, the threshold is 3 and the divide ratio is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pix_x | output | 12 | Active column |
| pix_y | output | 12 | Active row |
| last_line | output | 1 | Row equals line threshold |
| frame_irq | output | 1 | Frame interrupt pending |

## Verification
The bench keeps the default widths of 8-bit porch fields and 12-bit coordinates. It programs tiny rasters, with segments of one to six pixels or lines, so that complete frames last only tens of pixels. Every segment transition and every frame wrap is therefore compared cycle by cycle against an arithmetic position model. The rasters are swept across divide ratios 1, 2, 3, 4 and the clamped 255. With frames this short, each run can also cover deferred updates, write-one-to-clear and the frame-synchronised enable over several boundaries.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int PW   = 8;
    localparam int CW   = 12;
    localparam int DIVW = 8;
    localparam int AW   = 3;
    localparam int DW   = 32;
    localparam int NSEG = 4;
    localparam int SIZE_H_LSB = 16;

    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_BACK   = 2'd1,
        SEG_ACTIVE = 2'd2,
        SEG_FRONT  = 2'd3
    } seg_e;

    typedef struct packed {
        logic [PW-1:0] h_sync;
        logic [PW-1:0] h_back;
        logic [PW-1:0] h_front;
        logic [PW-1:0] v_sync;
        logic [PW-1:0] v_back;
        logic [PW-1:0] v_front;
        logic [CW-1:0] h_act;
        logic [CW-1:0] v_act;
        logic [CW-1:0] thr;
    } tcfg_t;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_VTIM = 3'd1;
    localparam logic [AW-1:0] A_HTIM = 3'd2;
    localparam logic [AW-1:0] A_SIZE = 3'd3;
    localparam logic [AW-1:0] A_THR  = 3'd4;
    localparam logic [AW-1:0] A_DIV  = 3'd5;
    localparam logic [AW-1:0] A_IRQ  = 3'd6;

    localparam int B_EN   = 0;
    localparam int B_ENF  = 1;
    localparam int B_IRQE = 2;
    localparam int B_SRST = 3;
    localparam int B_UPD  = 4;

    localparam logic [DIVW-1:0] DIV_MAX = {{(DIVW-1){1'b1}}, 1'b0};

    localparam tcfg_t CFG_RESET = '{
        h_sync: '0, h_back: '0, h_front: '0,
        v_sync: '0, v_back: '0, v_front: '0,
        h_act: CW'(3), v_act: CW'(3), thr: CW'(3)
    };
endpackage

// File: rtl/dtg_cfg_regs.sv
module dtg_cfg_regs
    import dtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            frame_wrap,
    output tcfg_t           act_cfg,
    output logic [DIVW-1:0] div_m1,
    output logic            srst_pulse,
    output logic            video_on,
    output logic            irq_pending
);
    tcfg_t shadow_q, shadow_nx;
    logic  en_q, enf_req_q, enf_live_q, irqen_q, upd_q;
    logic  enf_req_nx, irqen_nx, upd_nx;
    logic  ctrl_wr, irq_clr, boundary;
    logic  unused_bits;

    assign unused_bits = ^wr_data;
    assign ctrl_wr     = wr_en && (wr_addr == A_CTRL);
    assign irq_clr     = wr_en && (wr_addr == A_IRQ) && wr_data[0];
    assign srst_pulse  = ctrl_wr && wr_data[B_SRST];
    assign boundary    = frame_wrap || srst_pulse;

    always_comb begin
        shadow_nx = shadow_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_VTIM: begin
                    shadow_nx.v_sync  = wr_data[PW-1:0];
                    shadow_nx.v_back  = wr_data[2*PW-1:PW];
                    shadow_nx.v_front = wr_data[3*PW-1:2*PW];
                end
                A_HTIM: begin
                    shadow_nx.h_sync  = wr_data[PW-1:0];
                    shadow_nx.h_back  = wr_data[2*PW-1:PW];
                    shadow_nx.h_front = wr_data[3*PW-1:2*PW];
                end
                A_SIZE: begin
                    shadow_nx.h_act = wr_data[CW-1:0];
                    shadow_nx.v_act = wr_data[SIZE_H_LSB+CW-1:SIZE_H_LSB];
                end
                A_THR:   shadow_nx.thr = wr_data[CW-1:0];
                default: shadow_nx = shadow_q;
            endcase
        end
    end

    always_comb begin
        enf_req_nx = ctrl_wr ? wr_data[B_ENF]  : enf_req_q;
        irqen_nx   = ctrl_wr ? wr_data[B_IRQE] : irqen_q;
        upd_nx     = upd_q || (ctrl_wr && wr_data[B_UPD]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q   <= CFG_RESET;
            act_cfg    <= CFG_RESET;
            en_q       <= 1'b0;
            enf_req_q  <= 1'b0;
            enf_live_q <= 1'b0;
            irqen_q    <= 1'b0;
            upd_q      <= 1'b0;
        end else begin
            shadow_q  <= shadow_nx;
            enf_req_q <= enf_req_nx;
            irqen_q   <= irqen_nx;
            if (ctrl_wr) en_q <= wr_data[B_EN];
            if (boundary) begin
                enf_live_q <= enf_req_nx;
                upd_q      <= 1'b0;
                if (upd_nx) act_cfg <= shadow_nx;
            end else begin
                upd_q <= upd_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_m1 <= '0;
        end else if (wr_en && (wr_addr == A_DIV)) begin
            div_m1 <= (wr_data[DIVW-1:0] == {DIVW{1'b1}}) ? DIV_MAX : wr_data[DIVW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      irq_pending <= 1'b0;
        else if (srst_pulse)             irq_pending <= 1'b0;
        else if (frame_wrap && irqen_nx) irq_pending <= 1'b1;
        else if (irq_clr)                irq_pending <= 1'b0;
    end

    assign video_on = en_q && enf_live_q;
endmodule

// File: rtl/dtg_pix_div.sv
module dtg_pix_div
    import dtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [DIVW-1:0] div_m1,
    output logic            pix_ce
);
    logic [DIVW-1:0] dc_q;

    assign pix_ce = (dc_q >= div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dc_q <= '0;
        else if (clr)    dc_q <= '0;
        else if (pix_ce) dc_q <= '0;
        else             dc_q <= dc_q + 1'b1;
    end
endmodule

// File: rtl/dtg_seg_fsm.sv
module dtg_seg_fsm
    import dtg_pkg::*;
#(
    parameter int W = CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step,
    input  logic [NSEG-1:0][W-1:0] lens,
    output logic [W-1:0]         coord,
    output logic                 in_sync,
    output logic                 in_act,
    output logic                 wrap
);
    seg_e         seg_q, seg_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         at_end;

    assign at_end = (cnt_q == lens[seg_q]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        seg_d = seg_q;
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (clr) begin
            seg_d = SEG_SYNC;
            cnt_d = '0;
        end else if (step) begin
            if (at_end) begin
                cnt_d = '0;
                unique case (seg_q)
                    SEG_SYNC:   seg_d = SEG_BACK;
                    SEG_BACK:   seg_d = SEG_ACTIVE;
                    SEG_ACTIVE: seg_d = SEG_FRONT;
                    SEG_FRONT: begin
                        seg_d = SEG_SYNC;
                        wrap  = 1'b1;
                    end
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        in_sync = (seg_q == SEG_SYNC);
        in_act  = (seg_q == SEG_ACTIVE);
        coord   = in_act ? cnt_q : '0;
    end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pix_ce,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic          last_line,
    output logic          frame_irq
);
    localparam int NAXIS = 2;
    localparam int EXT   = CW - PW;

    tcfg_t           act_cfg;
    logic [DIVW-1:0] div_m1;
    logic            srst_pulse, video_on, v_wrap, h_wrap;
    logic [NSEG-1:0][CW-1:0] axis_lens [NAXIS];
    logic [CW-1:0]   axis_coord [NAXIS];
    logic            axis_sync  [NAXIS];
    logic            axis_act   [NAXIS];
    logic            axis_wrap  [NAXIS];

    dtg_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_wrap(v_wrap), .act_cfg(act_cfg),
        .div_m1(div_m1), .srst_pulse(srst_pulse), .video_on(video_on),
        .irq_pending(frame_irq)
    );

    dtg_pix_div u_div (
        .clk(clk), .rst_n(rst_n), .clr(srst_pulse), .div_m1(div_m1), .pix_ce(pix_ce)
    );

    always_comb begin
        axis_lens[0][SEG_SYNC]   = {{EXT{1'b0}}, act_cfg.h_sync};
        axis_lens[0][SEG_BACK]   = {{EXT{1'b0}}, act_cfg.h_back};
        axis_lens[0][SEG_ACTIVE] = act_cfg.h_act;
        axis_lens[0][SEG_FRONT]  = {{EXT{1'b0}}, act_cfg.h_front};
        axis_lens[1][SEG_SYNC]   = {{EXT{1'b0}}, act_cfg.v_sync};
        axis_lens[1][SEG_BACK]   = {{EXT{1'b0}}, act_cfg.v_back};
        axis_lens[1][SEG_ACTIVE] = act_cfg.v_act;
        axis_lens[1][SEG_FRONT]  = {{EXT{1'b0}}, act_cfg.v_front};
    end

    for (genvar g = 0; g < NAXIS; g++) begin : g_axis
        logic step_g;
        if (g == 0) begin : g_h
            assign step_g = pix_ce;
        end else begin : g_v
            assign step_g = pix_ce && h_wrap;
        end
        dtg_seg_fsm #(.W(CW)) u_seg (
            .clk(clk), .rst_n(rst_n), .clr(srst_pulse), .step(step_g),
            .lens(axis_lens[g]), .coord(axis_coord[g]), .in_sync(axis_sync[g]),
            .in_act(axis_act[g]), .wrap(axis_wrap[g])
        );
    end

    assign h_wrap    = axis_wrap[0];
    assign v_wrap    = axis_wrap[1];
    assign hsync     = axis_sync[0];
    assign vsync     = axis_sync[1];
    assign pix_x     = axis_coord[0];
    assign pix_y     = axis_coord[1];
    assign de        = axis_act[0] && axis_act[1] && video_on;
    assign last_line = axis_act[1] && (axis_coord[1] == act_cfg.thr);
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          hsync,
    input logic          vsync,
    input logic          de,
    input logic          pix_ce,
    input logic [CW-1:0] pix_x,
    input logic          last_line,
    input logic          frame_irq,
    input logic          srst_pulse,
    input logic          frame_start,
    input tcfg_t         act_cfg
);
    assert_blank_in_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync || vsync) |-> !de);

    assert_hold_between_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_ce && !srst_pulse) |=> ($stable(hsync) && $stable(pix_x)));

    assert_cfg_only_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !srst_pulse) |=> $stable(act_cfg));

    assert_irq_with_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_irq) |-> $rose(vsync));

    assert_last_line_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_line |-> !vsync);

    assert_srst_clears_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pulse |=> (!frame_irq && hsync && vsync));
endmodule

bind disp_timing_gen dtg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_ce(pix_ce), .pix_x(pix_x), .last_line(last_line), .frame_irq(frame_irq),
    .srst_pulse(srst_pulse), .frame_start(v_wrap), .act_cfg(act_cfg)
);

// File: tb/disp_timing_gen_tb_top.sv
module disp_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pix_ce, hsync, vsync, de, last_line, frame_irq;
    logic [11:0] pix_x, pix_y;

    int checks = 0, fails = 0, cyc = 0, irq_seen = 0, de_seen = 0;
    bit chk_on = 0;
    string phase = "R10";

    // model state: running set, shadow set, control
    int m_hs, m_hb, m_ha, m_hf, m_vs, m_vb, m_va, m_vf, m_thr;
    int s_hs, s_hb, s_ha, s_hf, s_vs, s_vb, s_va, s_vf, s_thr;
    int m_div, dcm, hp, vp;
    bit en, enf_req, enf_live, irqen, upd, irqp;

    always #4 clk = ~clk;

    disp_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x),
        .pix_y(pix_y), .last_line(last_line), .frame_irq(frame_irq)
    );

    task automatic model_init();
        m_hs = 1; m_hb = 1; m_ha = 4; m_hf = 1; m_vs = 1; m_vb = 1; m_va = 4; m_vf = 1; m_thr = 3;
        s_hs = 1; s_hb = 1; s_ha = 4; s_hf = 1; s_vs = 1; s_vb = 1; s_va = 4; s_vf = 1; s_thr = 3;
        m_div = 0; dcm = 0; hp = 0; vp = 0;
        en = 0; enf_req = 0; enf_live = 0; irqen = 0; upd = 0; irqp = 0;
    endtask

    task automatic model_edge();
        bit ce, wrap, srst, w1c;
        int d;
        ce = (dcm >= m_div);
        wrap = 0; srst = 0; w1c = 0;
        dcm = ce ? 0 : dcm + 1;
        if (ce) begin
            if (hp == m_hs + m_hb + m_ha + m_hf - 1) begin
                hp = 0;
                if (vp == m_vs + m_vb + m_va + m_vf - 1) begin vp = 0; wrap = 1; end
                else vp = vp + 1;
            end else hp = hp + 1;
        end
        d = int'(wr_data);
        if (wr_en) begin
            case (wr_addr)
                3'd0: begin
                    en = d[0]; enf_req = d[1]; irqen = d[2];
                    if (d[4]) upd = 1;
                    srst = d[3];
                end
                3'd1: begin s_vs = (d & 255) + 1; s_vb = ((d >> 8) & 255) + 1; s_vf = ((d >> 16) & 255) + 1; end
                3'd2: begin s_hs = (d & 255) + 1; s_hb = ((d >> 8) & 255) + 1; s_hf = ((d >> 16) & 255) + 1; end
                3'd3: begin s_ha = (d & 4095) + 1; s_va = ((d >> 16) & 4095) + 1; end
                3'd4: s_thr = d & 4095;
                3'd5: m_div = ((d & 255) == 255) ? 254 : (d & 255);
                3'd6: w1c = d[0];
                default: ;
            endcase
        end
        if (srst) begin hp = 0; vp = 0; dcm = 0; wrap = 0; end
        if (srst) irqp = 0;
        else if (wrap && irqen) irqp = 1;
        else if (w1c) irqp = 0;
        if (srst || wrap) begin
            enf_live = enf_req;
            if (upd) begin
                m_hs = s_hs; m_hb = s_hb; m_ha = s_ha; m_hf = s_hf;
                m_vs = s_vs; m_vb = s_vb; m_va = s_va; m_vf = s_vf; m_thr = s_thr;
                upd = 0;
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_init();
        else begin
            model_edge();
            cyc = cyc + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) act=%0d exp=%0d t=%0t", tag, phase, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            int hst, vst;
            bit ha, va, ex_de;
            hst = m_hs + m_hb; vst = m_vs + m_vb;
            ha = (hp >= hst) && (hp < hst + m_ha);
            va = (vp >= vst) && (vp < vst + m_va);
            ex_de = ha && va && en && enf_live;
            chk("hsync R1", int'(hsync), int'(hp < m_hs));
            chk("vsync R2", int'(vsync), int'(vp < m_vs));
            chk("pix_x R3", int'(pix_x), ha ? hp - hst : 0);
            chk("pix_y R3", int'(pix_y), va ? vp - vst : 0);
            chk("de R7", int'(de), int'(ex_de));
            chk("last_line R8", int'(last_line), int'(va && (vp - vst == m_thr)));
            chk("frame_irq R5", int'(frame_irq), int'(irqp));
            chk("pix_ce R6", int'(pix_ce), int'(dcm >= m_div));
            if (frame_irq) irq_seen++;
            if (de) de_seen++;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int frame_len();
        return (m_hs + m_hb + m_ha + m_hf) * (m_vs + m_vb + m_va + m_vf) * (m_div + 1);
    endfunction

    // configs: hs hb ha hf vs vb va vf thr divfield
    int cfg [6][10] = '{
        '{1, 1, 4, 1, 1, 1, 3, 1, 2, 0},
        '{2, 3, 5, 1, 1, 2, 4, 2, 3, 1},
        '{1, 2, 3, 2, 2, 1, 2, 1, 0, 2},
        '{3, 1, 6, 2, 2, 2, 3, 1, 1, 0},
        '{1, 1, 1, 1, 1, 1, 1, 1, 0, 3},
        '{2, 2, 4, 3, 1, 1, 2, 2, 1, 255}
    };

    task automatic load_cfg(int i, bit go);
        wr(5, cfg[i][9]);
        wr(1, (cfg[i][4] - 1) | ((cfg[i][5] - 1) << 8) | ((cfg[i][7] - 1) << 16));
        wr(2, (cfg[i][0] - 1) | ((cfg[i][1] - 1) << 8) | ((cfg[i][3] - 1) << 16));
        wr(3, (cfg[i][2] - 1) | ((cfg[i][6] - 1) << 16));
        wr(4, cfg[i][8]);
        if (go) wr(0, 32'h1F);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        run(2);
        #1;
        chk("reset hsync R10", int'(hsync), 1);
        chk("reset vsync R10", int'(vsync), 1);
        chk("reset de R10", int'(de), 0);
        chk("reset irq R10", int'(frame_irq), 0);
        chk("reset pix_x R10", int'(pix_x), 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        phase = "R10";
        run(80);

        phase = "R6/R9";
        for (int i = 0; i < 6; i++) begin
            load_cfg(i, 1'b1);
            run((i == 5) ? frame_len() + 20 : 2 * frame_len() + 7);
        end

        phase = "R4";
        load_cfg(1, 1'b1);
        run(frame_len() / 2);
        load_cfg(3, 1'b0);
        run(2 * frame_len());
        chk("no update applied R4", m_ha, 5);
        wr(0, 32'h17);
        run(3 * frame_len());
        chk("update applied R4", m_ha, 6);

        phase = "R5";
        run(frame_len());
        wr(6, 0);
        run(3);
        wr(6, 1);
        run(3);
        run(frame_len());

        phase = "R7";
        wr(0, 32'h05);
        run(frame_len() / 2);
        run(2 * frame_len());
        wr(0, 32'h07);
        run(frame_len() / 3);
        wr(0, 32'h06);
        run(frame_len());
        wr(0, 32'h07);
        run(2 * frame_len());

        chk("irq observed R5", int'(irq_seen > 0), 1);
        chk("de observed R7", int'(de_seen > 0), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule